// File: doc/BRIEF.md
# VCONN Overcurrent Supervisor

This block controls the power switch that supplies VCONN to a USB Type-C cable. While a cable is attached and the CC detection logic asks for VCONN (Ra seen on the spare pin), the block turns on the switch that drives the CC pin opposite the active CC line. The orientation is latched when the switch turns on. The block also holds a programmable current-limit code for the analog switch. The analog side sends back a digital overcurrent flag that is valid for the limit currently in force.

Faults are handled in two stages, and a millisecond tick sets the timing. The overcurrent flag must stay high for a qualification window before an interrupt is raised. Software then has a grace window to raise the limit or remove it. If it does not, the switch is forced off and a fault status bit is set. After a forced shutdown the switch stays off until the VCONN request is dropped and asserted again. Both status bits are cleared by write-one-to-clear strobes.

Top module: `vconn_ocp_ctrl`

## Requirements
- R1: With `attached_i` and `vconn_req_i` both high, the switch turns on one cycle later on the pin opposite the active CC line. `active_cc_i`=0 drives `en_cc2_o` and `active_cc_i`=1 drives `en_cc1_o`. The side is latched at turn-on and does not follow later changes of `active_cc_i`.
- R2: Limit codes are 0=200 mA, 1=300 mA, 2=400 mA, 3=500 mA and 4=no limit. The code resets to 0. A `lim_wr_i` strobe with a code of 5 to 7 is ignored. `lim_code_o` shows the accepted code from the cycle after the write.
- R3: While the switch is on, `irq_o` rises in the cycle after the third `tick_ms_i` pulse counted with `oc_flag_i` held high throughout.
- R4: A cycle with `oc_flag_i` low before qualification completes resets the tick count, so three new ticks are needed.
- R5: After the interrupt, 12 ticks with no raise of the limit (whatever the flag does) turn both enables off and set `fault_o`, both visible in the cycle after the twelfth tick.
- R6: A valid write of a code higher than the current one during the grace window keeps the switch on and ends the window. Code 4 counts as the highest. This holds even when the write falls in the same cycle as the twelfth tick. A write of an equal or lower code updates the limit but does not rescue the switch.
- R7: After a fault shutdown the switch stays off while `vconn_req_i` stays high. It turns on again one cycle after the request has been low and is raised again.
- R8: `en_cc1_o` and `en_cc2_o` are never high together. Both are low in the cycle after `attached_i` falls.
- R9: `sts_clr_i[0]` clears `irq_o` and `sts_clr_i[1]` clears `fault_o`. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| attached_i | input | 1 | Port partner attached |
| vconn_req_i | input | 1 | VCONN requested (Ra detected) |
| active_cc_i | input | 1 | Active CC line: 0 = CC1, 1 = CC2 |
| oc_flag_i | input | 1 | Overcurrent comparator flag |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | 3 | Limit code to write |
| sts_clr_i | input | 2 | Write-one-to-clear: bit 0 interrupt, bit 1 fault |
| en_cc1_o | output | 1 | Switch enable toward CC1 |
| en_cc2_o | output | 1 | Switch enable toward CC2 |
| lim_code_o | output | 3 | Current-limit code to the analog switch |
| irq_o | output | 1 | Overcurrent interrupt |
| fault_o | output | 1 | Fault shutdown status |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a limit-raising write and the twelfth grace tick that would force the shutdown. The second pair is an interrupt or fault being set and a clear strobe for the same bit. The bench drives each pair in one cycle on purpose. It then checks that the switch stays on, that `lim_code_o` takes the new code, and that the status bit still reads high in the following cycle. Random limit writes and random attach, request and orientation patterns are compared with a bench model of the limit register and of the enable routing.

// File: rtl/vconn_ocp_pkg.sv
package vconn_ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ON    = 2'd1,
    ST_GRACE = 2'd2,
    ST_OFF   = 2'd3
  } sup_state_e;

  localparam int unsigned CLR_IRQ = 0;
  localparam int unsigned CLR_FLT = 1;
endpackage

// File: rtl/vconn_lim_reg.sv
module vconn_lim_reg #(
  parameter int unsigned LIM_W   = 3,
  parameter int unsigned LIM_MAX = 4,
  parameter int unsigned LIM_RST = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LIM_W-1:0] wdata_i,
  output logic [LIM_W-1:0] lim_o,
  output logic             raise_o
);
  logic [LIM_W-1:0] lim_q;
  logic             valid;

  assign valid   = (wdata_i <= LIM_W'(LIM_MAX));
  // higher code is always a looser limit; top code means unlimited
  assign raise_o = wr_i && valid && (wdata_i > lim_q);
  assign lim_o   = lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lim_q <= LIM_W'(LIM_RST);
    else if (wr_i && valid) lim_q <= wdata_i;
  end
endmodule

// File: rtl/vconn_ms_timer.sv
module vconn_ms_timer #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = inc_i && !clr_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vconn_sup_fsm.sv
module vconn_sup_fsm
  import vconn_ocp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_i,
  input  logic       active_cc_i,
  input  logic       qual_done_i,
  input  logic       grace_done_i,
  input  logic       raise_i,
  input  logic [1:0] sts_clr_i,
  output sup_state_e state_o,
  output logic       en_cc1_o,
  output logic       en_cc2_o,
  output logic       irq_o,
  output logic       fault_o,
  output logic       irq_set_o
);
  sup_state_e st_q, st_d;
  logic side_q, side_d;
  logic irq_q, flt_q, flt_set, pwr;

  always_comb begin
    st_d    = st_q;
    side_d  = side_q;
    irq_set_o = 1'b0;
    flt_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (link_i) begin
        st_d   = ST_ON;
        side_d = active_cc_i;
      end
      ST_ON: begin
        if (!link_i) st_d = ST_IDLE;
        else if (qual_done_i) begin
          st_d      = ST_GRACE;
          irq_set_o = 1'b1;
        end
      end
      ST_GRACE: begin
        if (!link_i)           st_d = ST_IDLE;
        else if (raise_i)      st_d = ST_ON;
        else if (grace_done_i) begin
          st_d    = ST_OFF;
          flt_set = 1'b1;
        end
      end
      ST_OFF:  if (!link_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      side_q <= 1'b0;
      irq_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      side_q <= side_d;
      irq_q  <= irq_set_o | (irq_q & ~sts_clr_i[CLR_IRQ]);
      flt_q  <= flt_set   | (flt_q & ~sts_clr_i[CLR_FLT]);
    end
  end

  assign pwr      = (st_q == ST_ON) || (st_q == ST_GRACE);
  // supply the pin that is not carrying the cable's CC line
  assign en_cc1_o = pwr &&  side_q;
  assign en_cc2_o = pwr && !side_q;
  assign irq_o    = irq_q;
  assign fault_o  = flt_q;
  assign state_o  = st_q;
endmodule

// File: rtl/vconn_ocp_ctrl.sv
module vconn_ocp_ctrl
  import vconn_ocp_pkg::*;
#(
  parameter int unsigned QUAL_MS  = 3,
  parameter int unsigned GRACE_MS = 12,
  parameter int unsigned LIM_W    = 3,
  parameter int unsigned LIM_MAX  = 4,
  parameter int unsigned LIM_RST  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_ms_i,
  input  logic             attached_i,
  input  logic             vconn_req_i,
  input  logic             active_cc_i,
  input  logic             oc_flag_i,
  input  logic             lim_wr_i,
  input  logic [LIM_W-1:0] lim_wdata_i,
  input  logic [1:0]       sts_clr_i,
  output logic             en_cc1_o,
  output logic             en_cc2_o,
  output logic [LIM_W-1:0] lim_code_o,
  output logic             irq_o,
  output logic             fault_o
);
  sup_state_e state;
  logic link, raise, qual_done, grace_done;
  logic in_on, in_grace;
  logic off_w, irq_set_w;

  assign link     = attached_i && vconn_req_i;
  assign in_on    = (state == ST_ON);
  assign in_grace = (state == ST_GRACE);
  assign off_w    = (state == ST_OFF);

  vconn_lim_reg #(
    .LIM_W  (LIM_W),
    .LIM_MAX(LIM_MAX),
    .LIM_RST(LIM_RST)
  ) u_lim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (lim_wr_i),
    .wdata_i(lim_wdata_i),
    .lim_o  (lim_code_o),
    .raise_o(raise)
  );

  // qualification: any low flag sample restarts the window
  vconn_ms_timer #(.LIMIT(QUAL_MS)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!(in_on && oc_flag_i)),
    .inc_i (tick_ms_i),
    .done_o(qual_done)
  );

  vconn_ms_timer #(.LIMIT(GRACE_MS)) u_grace (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_grace || raise),
    .inc_i (tick_ms_i),
    .done_o(grace_done)
  );

  vconn_sup_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_i      (link),
    .active_cc_i (active_cc_i),
    .qual_done_i (qual_done),
    .grace_done_i(grace_done),
    .raise_i     (raise),
    .sts_clr_i   (sts_clr_i),
    .state_o     (state),
    .en_cc1_o    (en_cc1_o),
    .en_cc2_o    (en_cc2_o),
    .irq_o       (irq_o),
    .fault_o     (fault_o),
    .irq_set_o   (irq_set_w)
  );
endmodule

// File: rtl/vconn_ocp_ctrl_chk.sv
module vconn_ocp_ctrl_chk #(
  parameter int unsigned LIM_W   = 3,
  parameter int unsigned LIM_MAX = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             attached_i,
  input logic             vconn_req_i,
  input logic             active_cc_i,
  input logic             oc_flag_i,
  input logic             lim_wr_i,
  input logic [LIM_W-1:0] lim_wdata_i,
  input logic [1:0]       sts_clr_i,
  input logic             en_cc1_o,
  input logic             en_cc2_o,
  input logic [LIM_W-1:0] lim_code_o,
  input logic             irq_o,
  input logic             fault_o,
  input logic             off_w,
  input logic             irq_set_w
);
  assert_en_side_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_cc1_o) |-> ($past(active_cc_i) && $past(vconn_req_i) && $past(attached_i)));

  assert_lim_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_wr_i && (lim_wdata_i > LIM_W'(LIM_MAX))) |=> $stable(lim_code_o));

  assert_irq_qual_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(oc_flag_i));

  assert_fault_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> (!en_cc1_o && !en_cc2_o));

  assert_latched_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_w && vconn_req_i) |=> (!en_cc1_o && !en_cc2_o));

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_cc1_o, en_cc2_o}));

  assert_detach_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attached_i |=> (!en_cc1_o && !en_cc2_o));

  assert_irq_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && sts_clr_i[0] && !irq_set_w) |=> !irq_o);
endmodule

bind vconn_ocp_ctrl vconn_ocp_ctrl_chk #(.LIM_W(LIM_W), .LIM_MAX(LIM_MAX)) u_chk (.*);

// File: tb/vconn_ocp_ctrl_test.sv
module vconn_ocp_ctrl_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_ms_i = 1'b0, attached_i = 1'b0, vconn_req_i = 1'b0, active_cc_i = 1'b0;
  logic oc_flag_i = 1'b0, lim_wr_i = 1'b0;
  logic [2:0] lim_wdata_i = 3'd0;
  logic [1:0] sts_clr_i = 2'b00;
  logic en_cc1_o, en_cc2_o, irq_o, fault_o;
  logic [2:0] lim_code_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  vconn_ocp_ctrl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms_i = 1'b1; step();
      tick_ms_i = 1'b0; step();
    end
  endtask

  task automatic wr_lim(input logic [2:0] c);
    lim_wr_i = 1'b1; lim_wdata_i = c; step();
    lim_wr_i = 1'b0;
  endtask

  function automatic int exp_en(input bit on, input bit side);
    return on ? (side ? 2 : 1) : 0;  // 2: CC1 powered, 1: CC2 powered
  endfunction

  function automatic int lim_next(input int cur, input int code);
    return (code <= 4) ? code : cur;
  endfunction

  initial begin
    int elim;
    bit m_on, m_side;
    void'($urandom(32'h5eed_1234));
    step(); step();
    chk("R2 reset limit", lim_code_o, 0);
    chk("R8 reset enables", {en_cc1_o, en_cc2_o}, 0);
    chk("R9 reset irq", irq_o, 0);
    chk("R9 reset fault", fault_o, 0);
    rst_ni = 1'b1; step();

    // R2: random limit writes, codes 5..7 must be ignored
    elim = 0;
    for (int i = 0; i < 40; i++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      wr_lim(c);
      elim = lim_next(elim, c);
      chk("R2 limit write", lim_code_o, elim);
    end

    // R1/R8: random attach/request/orientation, no overcurrent
    m_on = 0; m_side = 0;
    for (int i = 0; i < 60; i++) begin
      attached_i  = ($urandom_range(0, 3) != 0);
      vconn_req_i = ($urandom_range(0, 3) != 0);
      active_cc_i = 1'($urandom_range(0, 1));
      step();
      if (!(attached_i && vconn_req_i)) m_on = 0;
      else if (!m_on) begin m_on = 1; m_side = active_cc_i; end
      chk("R1 R8 routing", {en_cc1_o, en_cc2_o}, exp_en(m_on, m_side));
    end

    // directed: fresh connection, CC1 active -> CC2 powered
    attached_i = 0; vconn_req_i = 0; step();
    active_cc_i = 0; attached_i = 1; vconn_req_i = 1; step();
    chk("R1 turn on CC2", {en_cc1_o, en_cc2_o}, 1);
    active_cc_i = 1; step();
    chk("R1 side latched", {en_cc1_o, en_cc2_o}, 1);
    wr_lim(3'd0);

    // R4: two ticks, flag drop, then qualification restarts
    oc_flag_i = 1; ticks(2);
    chk("R4 no irq after 2", irq_o, 0);
    oc_flag_i = 0; step(); oc_flag_i = 1;
    ticks(2);
    chk("R4 count restarted", irq_o, 0);
    // R3 + R9 collision: third tick with irq clear strobe in the same cycle
    tick_ms_i = 1; sts_clr_i = 2'b01; step();
    tick_ms_i = 0; sts_clr_i = 2'b00;
    chk("R3 irq after 3 ticks", irq_o, 1);
    chk("R9 set wins over clear", irq_o, 1);
    oc_flag_i = 0;
    ticks(11);
    chk("R5 on after 11 grace", {en_cc1_o, en_cc2_o}, 1);
    // R6 collision: raise on the twelfth tick
    tick_ms_i = 1; lim_wr_i = 1; lim_wdata_i = 3'd4; step();
    tick_ms_i = 0; lim_wr_i = 0;
    chk("R6 raise wins on last tick", {en_cc1_o, en_cc2_o}, 1);
    chk("R6 raise accepted", lim_code_o, 4);
    chk("R6 no fault", fault_o, 0);
    ticks(14);
    chk("R6 stays on", {en_cc1_o, en_cc2_o}, 1);
    sts_clr_i = 2'b01; step(); sts_clr_i = 2'b00;
    chk("R9 irq cleared", irq_o, 0);

    // R5: no rescue -> shutdown
    wr_lim(3'd1);
    oc_flag_i = 1; ticks(3);
    chk("R3 irq second fault", irq_o, 1);
    wr_lim(3'd1);
    chk("R6 equal code no effect", lim_code_o, 1);
    wr_lim(3'd6);
    chk("R2 invalid ignored in grace", lim_code_o, 1);
    ticks(11);
    chk("R5 still on at 11", {en_cc1_o, en_cc2_o}, 1);
    tick_ms_i = 1; step(); tick_ms_i = 0;
    chk("R5 off at 12", {en_cc1_o, en_cc2_o}, 0);
    chk("R5 fault set", fault_o, 1);
    oc_flag_i = 0;
    ticks(5);
    chk("R7 latched off", {en_cc1_o, en_cc2_o}, 0);
    // fault clear while fault not re-set
    sts_clr_i = 2'b10; step(); sts_clr_i = 2'b00;
    chk("R9 fault cleared", fault_o, 0);
    vconn_req_i = 0; active_cc_i = 1; step();
    chk("R7 off with req low", {en_cc1_o, en_cc2_o}, 0);
    vconn_req_i = 1; step();
    chk("R7 re-enabled CC1", {en_cc1_o, en_cc2_o}, 2);

    // R8: detach clears enables next cycle
    attached_i = 0; step();
    chk("R8 detach clears", {en_cc1_o, en_cc2_o}, 0);
    chk("R1 no restart while detached", {en_cc1_o, en_cc2_o}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule